// File: doc/BRIEF.md
# Reset Hold Duration Meter

This block times how long an active-low reset line stays asserted, so that boot firmware can tell a deliberate long press of a reset key, such as a factory-restore request, from an ordinary short reset. The line is sampled through a two-flop synchroniser. A saturating counter, running on the 25 MHz reference clock (40 ns per count), advances once for each cycle the synchronised line is low. The counter keeps its value after the line returns high, so software can read the press length once it is running again.

A small register interface has two locations: the length register and a threshold register holding a whole number of seconds. Writing the length register with its top bit set clears the count and the long-press flag. This prepares the block for the next press. The long-press output rises when the count reaches the threshold times the number of ticks per second, and it stays high until it is cleared. The block runs on its own reset (`rst_n`). It must not be reset by the line it measures.

Top module: `reset_hold_meter`

## Requirements
- R1: After `rst_n` is released, the count, the threshold and `long_press` are all zero, and both register locations read as zero.
- R2: The line passes through two flops before it is used. The count first changes on the third rising edge after the line goes low. A low period of N cycles adds exactly N to the count.
- R3: The count holds while the synchronised line is high. A new low period adds to the held value unless a clear was written in between.
- R4: The count saturates at 2^CNT_W-1 and stays there while the line remains low. It never wraps.
- R5: A read at `addr`=0 returns the count in bits [CNT_W-1:0] and zeros in every bit above, bit 31 included.
- R6: A write to `addr`=0 with `wdata[31]`=1 zeroes the count and `long_press` on that edge. A write to `addr`=0 with `wdata[31]`=0 changes neither.
- R7: When a clear write and an increment fall on the same edge, the clear wins and the count becomes zero.
- R8: A write to `addr`=1 stores `wdata[THR_W-1:0]` as the threshold in seconds. A read at `addr`=1 returns it zero-extended.
- R9: With a non-zero threshold T, `long_press` rises one edge after the count first becomes greater than or equal to T×TICKS_PER_SEC. Below that value it stays low.
- R10: `long_press` is sticky. Only R6's clear or `rst_n` lowers it. A threshold of zero never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, 25 MHz by default |
| rst_n | input | 1 | Active-low reset of this block |
| hold_n | input | 1 | Asynchronous active-low reset line being timed |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register select: 0 length, 1 threshold |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the selected register, combinational |
| long_press | output | 1 | Sticky flag: hold length reached the threshold |

## Verification
A wrong count shows at `rdata` on the first read after the press. Because the count accumulates, an error made during one press still shows in every later read until a clear is written. A late or missing synchroniser stage moves the first increment by one edge, which a read of the count two and three cycles after the line falls exposes. A bad threshold product or a lost clear shows on `long_press` within one edge of the crossing or clearing point.

// File: rtl/rhm_pkg.sv
package rhm_pkg;
    localparam int  REG_DW      = 32;
    localparam bit  ADDR_LENGTH = 1'b0;
    localparam bit  ADDR_THRESH = 1'b1;
    localparam int  CLEAR_BIT   = 31;

    function automatic logic is_clear(input logic wr, input logic a, input logic [REG_DW-1:0] d);
        return wr && (a == ADDR_LENGTH) && d[CLEAR_BIT];
    endfunction
endpackage

// File: rtl/rhm_sync.sv
module rhm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{chain: '1};
        else        st_q <= st_d;
    end

    assign sync_out = st_q.chain[STAGES-1];
endmodule

// File: rtl/rhm_counter.sv
module rhm_counter #(
    parameter int CNT_W = 29
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic             clear,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] value;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear)
            st_d.value = '0;
        else if (advance && (st_q.value != CNT_MAX))
            st_d.value = st_q.value + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.value;
endmodule

// File: rtl/rhm_threshold.sv
module rhm_threshold #(
    parameter int CNT_W         = 29,
    parameter int THR_W         = 8,
    parameter int TICKS_PER_SEC = 25_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic [THR_W-1:0] thresh,
    input  logic             clear,
    output logic             flag
);
    localparam int TICK_W = $clog2(TICKS_PER_SEC + 1);
    localparam int LIM_W  = TICK_W + THR_W;
    localparam int CMP_W  = (LIM_W > CNT_W) ? LIM_W : CNT_W;

    typedef struct packed {
        logic hit;
    } thr_state_t;

    thr_state_t       st_d, st_q;
    logic [CMP_W-1:0] limit;
    logic [CMP_W-1:0] count_ext;
    logic             reached;

    always_comb begin
        limit     = CMP_W'(CMP_W'(thresh) * CMP_W'(TICKS_PER_SEC));
        count_ext = CMP_W'(count);
        reached   = (thresh != '0) && (count_ext >= limit);
        st_d      = st_q;
        if (clear)
            st_d.hit = 1'b0;
        else if (reached)
            st_d.hit = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.hit;
endmodule

// File: rtl/reset_hold_meter.sv
module reset_hold_meter #(
    parameter int CNT_W         = 29,
    parameter int THR_W         = 8,
    parameter int TICKS_PER_SEC = 25_000_000,
    parameter int SYNC_STAGES   = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hold_n,
    input  logic        wr_en,
    input  logic        addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        long_press
);
    import rhm_pkg::*;

    typedef struct packed {
        logic [THR_W-1:0] thresh;
    } top_state_t;

    top_state_t       st_d, st_q;
    logic             line_sync;
    logic             line_low;
    logic             clr_req;
    logic [CNT_W-1:0] count_q;
    logic [THR_W-1:0] thr_q;

    rhm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (hold_n),
        .sync_out (line_sync)
    );

    assign line_low = !line_sync;
    assign clr_req  = is_clear(wr_en, addr, wdata);

    rhm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (line_low),
        .clear   (clr_req),
        .count   (count_q)
    );

    rhm_threshold #(
        .CNT_W         (CNT_W),
        .THR_W         (THR_W),
        .TICKS_PER_SEC (TICKS_PER_SEC)
    ) u_thr (
        .clk    (clk),
        .rst_n  (rst_n),
        .count  (count_q),
        .thresh (thr_q),
        .clear  (clr_req),
        .flag   (long_press)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en && (addr == ADDR_THRESH))
            st_d.thresh = wdata[THR_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign thr_q = st_q.thresh;

    always_comb begin
        rdata = '0;
        if (addr == ADDR_LENGTH)
            rdata[CNT_W-1:0] = count_q;
        else
            rdata[THR_W-1:0] = thr_q;
    end
endmodule

// File: rtl/reset_hold_meter_checker.sv
module reset_hold_meter_checker #(
    parameter int CNT_W = 29,
    parameter int THR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             addr,
    input logic [31:0]      wdata,
    input logic [31:0]      rdata,
    input logic             line_low,
    input logic [CNT_W-1:0] count_q,
    input logic [THR_W-1:0] thr_q,
    input logic             long_press
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic clr;
    assign clr = wr_en && !addr && wdata[31];

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count_q == '0) && !long_press); // R7

    AST_HOLD_WHEN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_low && !clr) |=> $stable(count_q)); // R3

    AST_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        ((count_q == CNT_MAX) && !clr) |=> (count_q == CNT_MAX)); // R4

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (line_low && !clr && (count_q != CNT_MAX)) |=> (count_q == $past(count_q) + 1'b1)); // R2

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !addr |-> (rdata[31:CNT_W] == '0)); // R5

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (long_press && !clr) |=> long_press); // R10

    AST_FLAG_NEEDS_THR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(long_press) |-> ($past(thr_q) != '0)); // R9
endmodule

bind reset_hold_meter reset_hold_meter_checker #(
    .CNT_W (CNT_W),
    .THR_W (THR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .rdata      (rdata),
    .line_low   (line_low),
    .count_q    (count_q),
    .thr_q      (thr_q),
    .long_press (long_press)
);

// File: tb/reset_hold_meter_test.sv
module reset_hold_meter_test;
    localparam int CLK_PERIOD = 40;
    localparam int CNT_W      = 6;
    localparam int THR_W      = 4;
    localparam int TPS        = 4;
    localparam int NV         = 10;

    // fields: thr[21:18] clear[17] low_cycles[16:9] exp_count[8:1] exp_flag[0]
    localparam logic [21:0] VEC [NV] = '{
        {4'd0,  1'b1, 8'd5,  8'd5,  1'b0},  // R2
        {4'd0,  1'b0, 8'd3,  8'd8,  1'b0},  // R3 accumulate
        {4'd2,  1'b0, 8'd1,  8'd9,  1'b1},  // R9
        {4'd2,  1'b1, 8'd7,  8'd7,  1'b0},  // R6 clear, below limit
        {4'd2,  1'b0, 8'd1,  8'd8,  1'b1},  // R9 equal to limit
        {4'd3,  1'b1, 8'd11, 8'd11, 1'b0},  // R9 one below
        {4'd3,  1'b0, 8'd1,  8'd12, 1'b1},  // R9 reached
        {4'd15, 1'b1, 8'd70, 8'd63, 1'b1},  // R4 R5 saturate
        {4'd0,  1'b0, 8'd10, 8'd63, 1'b1},  // R4 hold max, R10 sticky
        {4'd0,  1'b1, 8'd20, 8'd20, 1'b0}   // R10 zero threshold
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hold_n = 1'b1;
    logic        wr_en = 1'b0;
    logic        addr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        long_press;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    reset_hold_meter #(
        .CNT_W         (CNT_W),
        .THR_W         (THR_W),
        .TICKS_PER_SEC (TPS)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_n     (hold_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .long_press (long_press)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic read_reg(input logic a, output logic [31:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic press(input int n);
        hold_n = 1'b0;
        repeat (n) @(negedge clk);
        hold_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        read_reg(1'b0, r); check("R1 count", r, 32'h0);
        read_reg(1'b1, r); check("R1 threshold", r, 32'h0);
        check("R1 flag", {31'b0, long_press}, 32'h0);

        // R2 synchroniser latency: first increment on third edge
        hold_n = 1'b0;
        repeat (2) @(negedge clk);
        read_reg(1'b0, r); check("R2 no count after two edges", r, 32'h0);
        @(negedge clk);
        read_reg(1'b0, r); check("R2 first count on third edge", r, 32'h1);
        hold_n = 1'b1;
        repeat (4) @(negedge clk);

        // table walk
        for (int i = 0; i < NV; i++) begin
            logic [21:0] v;
            v = VEC[i];
            if (v[17]) write_reg(1'b0, 32'h8000_0000);
            write_reg(1'b1, {28'b0, v[21:18]});
            press(int'(v[16:9]));
            read_reg(1'b0, r);
            check($sformatf("R2/R3/R4/R5 vector %0d count", i), r, {24'b0, v[8:1]});
            check($sformatf("R9/R10 vector %0d flag", i), {31'b0, long_press}, {31'b0, v[0]});
        end

        // R6: write with bit 31 clear has no effect (count 20, flag 0)
        write_reg(1'b1, 32'h1);          // limit 4, sets flag
        @(negedge clk);
        write_reg(1'b0, 32'h7FFF_FFFF);
        read_reg(1'b0, r); check("R6 count kept", r, 32'd20);
        check("R6 flag kept", {31'b0, long_press}, 32'h1);
        write_reg(1'b0, 32'h8000_0000);
        read_reg(1'b0, r); check("R6 count cleared", r, 32'h0);
        write_reg(1'b1, 32'h0);
        check("R6 flag cleared", {31'b0, long_press}, 32'h0);

        // R7: clear on the same edge as an increment
        hold_n = 1'b0;
        repeat (6) @(negedge clk);
        wr_en = 1'b1; addr = 1'b0; wdata = 32'h8000_0000;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
        read_reg(1'b0, r); check("R7 clear wins over increment", r, 32'h0);
        @(negedge clk);
        read_reg(1'b0, r); check("R7 counting resumes", r, 32'h1);
        hold_n = 1'b1;
        repeat (4) @(negedge clk);

        // R8: threshold masked to its width
        write_reg(1'b1, 32'hFFFF_FFF5);
        read_reg(1'b1, r); check("R8 threshold readback", r, 32'h5);

        // R1 again: reset clears everything
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        read_reg(1'b1, r); check("R1 threshold after reset", r, 32'h0);
        read_reg(1'b0, r); check("R1 count after reset", r, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule